// File: doc/BRIEF.md
# DMA Slot-Table Grant Sequencer

This block decides which DMA channel, and in which direction, gets the next transfer opportunity. Software fills a table of slots and then turns on the sequencer. While it is on, the sequencer looks at one slot per clock. If the request flag for that slot's channel and direction is high, it raises a one-cycle grant with the channel number and an RX/TX flag. It then moves to the next slot whether or not a grant was issued.

Each 32-bit table word holds four one-byte slots. A control register holds the enable bit and the index of the last slot in use. When the walk passes that index it returns to slot 0. The programming rule is to stop the sequencer, rewrite the table, and then enable it again. Turning it off sends the walk back to slot 0 and blocks all grants.

Top module: `slot_seq_top`

## Requirements
- R1: Table word `w` is written at byte address 0x800 + 4*w, for w below `TBL_WORDS`. Slot `4*w + k` is byte `k` of that word, at bits `8k+7:8k`. In a slot byte, bit 7 set marks an RX slot and bit 7 clear marks a TX slot. Bits 6:0 give the channel number.
- R2: The control register is at address 0. Bit 31 is the enable bit and bits 7:0 hold the last slot index in use. After reset the sequencer is disabled, the last index is 0 and `grantValid` is low.
- R3: While enabled, the sequencer visits slots 0, 1, 2, … in order, one per clock. After the clock edge at which slot `i` is current, `grantValid` is high for one cycle when that slot's request flag was high at that edge. `grantChan` and `grantRx` then carry that slot's channel and direction.
- R4: A slot whose request flag is low gives no grant, and the walk still advances to the next slot.
- R5: The slot after the last index is slot 0.
- R6: From the cycle after a write of 0 to the control register, no grant is issued. The next enable starts the walk at slot 0.
- R7: Reading the control register returns the enable bit and the last index, with all other bits 0. Reading a table word returns the value last written to it. A read of any other address returns 0.
- R8: A slot whose channel number is not below `NUM_CHAN` never produces a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from `regAddr` |
| txReq | input | NUM_CHAN | Per-channel TX request flags |
| rxReq | input | NUM_CHAN | Per-channel RX request flags |
| grantValid | output | 1 | One-cycle grant pulse |
| grantChan | output | 7 | Granted channel number |
| grantRx | output | 1 | High for an RX grant, low for a TX grant |

## Verification
The assertions assume that the last index is never set above the number of slots the table holds. They also assume that the request flags change only between clock edges, so the value seen at an edge is the one the grant answers. The stimulus changes requests and register strobes only on falling edges and always programs a last index inside the written words. It also reprograms the table only while the sequencer is off, which follows the stated programming rule. A reference walk in the bench follows the same register writes and predicts the grant on every cycle. This covers all-requests-high, sparse request, disable and re-enable windows.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;
  localparam int ENT_W    = 8;
  localparam int ENT_PER  = 4;
  localparam int WORD_W   = ENT_W * ENT_PER;
  localparam int CHAN_W   = ENT_W - 1;

  typedef struct packed {
    logic tblWr;
    logic selCtrl;
    logic selTbl;
    logic scanOn;
  } seqStrobe_t;
endpackage

// File: rtl/slot_seq_ctrl.sv
module slot_seq_ctrl
  import slot_seq_pkg::*;
#(
  parameter int TBL_WORDS = 64,
  parameter int ADDR_W    = 12,
  parameter int TBL_BASE  = 'h800,
  localparam int IDX_W    = $clog2(TBL_WORDS * ENT_PER),
  localparam int WIDX_W   = $clog2(TBL_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEnBit,
  input  logic [IDX_W-1:0]  wrLastIdx,
  output seqStrobe_t        stb,
  output logic [WIDX_W-1:0] wordAddr,
  output logic [IDX_W-1:0]  scanIdx,
  output logic [WORD_W-1:0] ctrlWord
);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(TBL_BASE);
  localparam logic [ADDR_W-1:0] END_V  = ADDR_W'(TBL_BASE + 4 * TBL_WORDS);

  logic             en;
  logic [IDX_W-1:0] lastIdx;
  logic [IDX_W-1:0] idx;
  logic             hitCtrl, hitTbl;

  assign hitCtrl  = (regAddr == '0);
  assign hitTbl   = (regAddr >= BASE_V) && (regAddr < END_V) && (regAddr[1:0] == 2'b00);
  assign wordAddr = regAddr[WIDX_W+1:2] - BASE_V[WIDX_W+1:2];

  always_comb begin
    stb.tblWr   = regWrEn && hitTbl;
    stb.selCtrl = hitCtrl;
    stb.selTbl  = hitTbl;
    stb.scanOn  = en;
  end

  assign scanIdx  = idx;
  assign ctrlWord = {en, {(WORD_W - 1 - IDX_W){1'b0}}, lastIdx};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      en      <= 1'b0;
      lastIdx <= '0;
    end else if (regWrEn && hitCtrl) begin
      en      <= wrEnBit;
      lastIdx <= wrLastIdx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               idx <= '0;
    else if (!en)            idx <= '0;
    else if (idx >= lastIdx) idx <= '0;
    else                     idx <= idx + 1'b1;
  end

  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (en && idx < lastIdx) |=> (idx == $past(idx) + 1'b1));
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (en && idx == lastIdx) |=> (idx == '0));
  p_off_home_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!en) |=> (idx == '0));
endmodule

// File: rtl/slot_seq_dp.sv
module slot_seq_dp
  import slot_seq_pkg::*;
#(
  parameter int NUM_CHAN  = 32,
  parameter int TBL_WORDS = 64,
  localparam int IDX_W    = $clog2(TBL_WORDS * ENT_PER),
  localparam int WIDX_W   = $clog2(TBL_WORDS),
  localparam int PAD_W    = 2 ** CHAN_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          stb,
  input  logic [WIDX_W-1:0]   wordAddr,
  input  logic [WORD_W-1:0]   wrData,
  input  logic [WORD_W-1:0]   ctrlWord,
  input  logic [IDX_W-1:0]    scanIdx,
  input  logic [NUM_CHAN-1:0] txReq,
  input  logic [NUM_CHAN-1:0] rxReq,
  output logic [WORD_W-1:0]   rdData,
  output logic                grantValid,
  output logic [CHAN_W-1:0]   grantChan,
  output logic                grantRx
);
  logic [WORD_W-1:0] tbl [TBL_WORDS];
  logic [WORD_W-1:0] curWord;
  logic [ENT_W-1:0]  curEnt;
  logic [PAD_W-1:0]  txPad, rxPad;
  logic              slotHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TBL_WORDS; i++) tbl[i] <= '0;
    end else if (stb.tblWr) begin
      tbl[wordAddr] <= wrData;
    end
  end

  always_comb begin
    if (stb.selCtrl)     rdData = ctrlWord;
    else if (stb.selTbl) rdData = tbl[wordAddr];
    else                 rdData = '0;
  end

  assign curWord = tbl[scanIdx[IDX_W-1:2]];
  assign curEnt  = curWord[ENT_W*scanIdx[1:0] +: ENT_W];
  assign txPad   = PAD_W'(txReq);
  assign rxPad   = PAD_W'(rxReq);
  assign slotHit = curEnt[ENT_W-1] ? rxPad[curEnt[CHAN_W-1:0]] : txPad[curEnt[CHAN_W-1:0]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      grantChan  <= '0;
      grantRx    <= 1'b0;
    end else begin
      grantValid <= stb.scanOn && slotHit;
      grantChan  <= curEnt[CHAN_W-1:0];
      grantRx    <= curEnt[ENT_W-1];
    end
  end

  p_quiet_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.scanOn) |=> (!grantValid));
  p_chan_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (32'(grantChan) < NUM_CHAN));
  p_rx_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.scanOn && slotHit && curEnt[ENT_W-1]) |=>
      (grantValid && grantRx && (((rxReq | $past(rxReq)) >> grantChan) & NUM_CHAN'(1)) != '0));
  p_tx_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.scanOn && slotHit && !curEnt[ENT_W-1]) |=> (grantValid && !grantRx));
endmodule

// File: rtl/slot_seq_top.sv
module slot_seq_top
  import slot_seq_pkg::*;
#(
  parameter int NUM_CHAN  = 32,
  parameter int TBL_WORDS = 64,
  parameter int ADDR_W    = 12,
  parameter int TBL_BASE  = 'h800,
  localparam int IDX_W    = $clog2(TBL_WORDS * ENT_PER),
  localparam int WIDX_W   = $clog2(TBL_WORDS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [WORD_W-1:0]   regWrData,
  output logic [WORD_W-1:0]   regRdData,
  input  logic [NUM_CHAN-1:0] txReq,
  input  logic [NUM_CHAN-1:0] rxReq,
  output logic                grantValid,
  output logic [CHAN_W-1:0]   grantChan,
  output logic                grantRx
);
  seqStrobe_t        stb;
  logic [WIDX_W-1:0] wordAddr;
  logic [IDX_W-1:0]  scanIdx;
  logic [WORD_W-1:0] ctrlWord;

  slot_seq_ctrl #(.TBL_WORDS(TBL_WORDS), .ADDR_W(ADDR_W), .TBL_BASE(TBL_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .wrEnBit(regWrData[WORD_W-1]), .wrLastIdx(regWrData[IDX_W-1:0]),
    .stb(stb), .wordAddr(wordAddr), .scanIdx(scanIdx), .ctrlWord(ctrlWord)
  );

  slot_seq_dp #(.NUM_CHAN(NUM_CHAN), .TBL_WORDS(TBL_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wordAddr(wordAddr), .wrData(regWrData),
    .ctrlWord(ctrlWord), .scanIdx(scanIdx), .txReq(txReq), .rxReq(rxReq),
    .rdData(regRdData), .grantValid(grantValid), .grantChan(grantChan), .grantRx(grantRx)
  );
endmodule

// File: tb/sim_slot_seq_top.sv
module sim_slot_seq_top;
  localparam int NCH = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [NCH-1:0] txReq = '0, rxReq = '0;
  logic        grantValid, grantRx;
  logic [6:0]  grantChan;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { bit v; int ch; bit rx; string tag; } expItem_t;
  expItem_t sbq[$];

  slot_seq_top u0 (.clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .txReq(txReq), .rxReq(rxReq),
    .grantValid(grantValid), .grantChan(grantChan), .grantRx(grantRx));

  always #2 clk = ~clk;

  // reference walk built from the requirements
  bit          mEn;
  int          mLast, mIdx;
  logic [31:0] mTbl [64];

  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mLast = 0; mIdx = 0;
      for (int i = 0; i < 64; i++) mTbl[i] = '0;
    end else begin
      expItem_t e;
      logic [7:0] ent;
      ent   = mTbl[mIdx / 4][8*(mIdx % 4) +: 8];
      e.ch  = int'(ent[6:0]);
      e.rx  = ent[7];
      e.v   = mEn && (e.ch < NCH) && (e.rx ? rxReq[e.ch % NCH] : txReq[e.ch % NCH]);
      if (!mEn)              e.tag = "R6";
      else if (e.ch >= NCH)  e.tag = "R8";
      else if (mIdx == mLast) e.tag = "R5";
      else if (e.v)          e.tag = "R3";
      else                   e.tag = "R4";
      sbq.push_back(e);
      if (!mEn || mIdx >= mLast) mIdx = 0; else mIdx = mIdx + 1;
      if (regWrEn) begin
        if (regAddr == 12'h000) begin
          mEn = regWrData[31]; mLast = int'(regWrData[7:0]);
        end else if (regAddr >= 12'h800 && regAddr < 12'h900 && regAddr[1:0] == 2'b00)
          mTbl[(regAddr - 12'h800) >> 2] = regWrData;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && sbq.size() > 0) begin
      expItem_t e;
      e = sbq.pop_front();
      total++;
      if (grantValid !== e.v || (e.v && (int'(grantChan) != e.ch || grantRx !== e.rx))) begin
        bad++;
        $display("FAIL %s grant: got v=%0b ch=%0d rx=%0b expected v=%0b ch=%0d rx=%0b",
                 e.tag, grantValid, grantChan, grantRx, e.v, e.ch, e.rx);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0; regAddr = '0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); regAddr = a; #1;
    total++;
    if (regRdData !== exp) begin
      bad++;
      $display("FAIL %s read 0x%03h: got 0x%08h expected 0x%08h", tag, a, regRdData, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R2 reset state
    total++;
    if (grantValid !== 1'b0) begin bad++; $display("FAIL R2 reset grant: got %0b expected 0", grantValid); end
    rd(12'h000, 32'h0, "R2");
    // R1 table layout: ch0 TX, ch0 RX, ch1 TX, ch1 RX / ch5 TX, ch31 RX, ch40 TX, ch2 RX / ...
    wr(12'h800, 32'h8101_8000);
    wr(12'h804, 32'h8228_9F05);
    wr(12'h808, 32'h1FA8_8303);
    rd(12'h800, 32'h8101_8000, "R1");
    rd(12'h804, 32'h8228_9F05, "R7");
    rd(12'h808, 32'h1FA8_8303, "R7");
    rd(12'h004, 32'h0, "R7");
    rd(12'h900, 32'h0, "R7");
    // R3 R5 R8: all requests high, 12 slots
    txReq = '1; rxReq = '1;
    wr(12'h000, 32'h8000_000B);
    rd(12'h000, 32'h8000_000B, "R2");
    repeat (30) @(negedge clk);
    // R4: sparse requests, ch0 and ch5 TX only
    txReq = 32'h0000_0021; rxReq = '0;
    repeat (30) @(negedge clk);
    // R6: disable, then reprogram and restart at slot 0
    txReq = '1; rxReq = '1;
    wr(12'h000, 32'h0);
    repeat (10) @(negedge clk);
    wr(12'h800, 32'h0083_1E81);
    rd(12'h800, 32'h0083_1E81, "R1");
    wr(12'h000, 32'h8000_0005);
    repeat (25) @(negedge clk);
    rxReq = 32'h8000_0002;
    repeat (15) @(negedge clk);
    wr(12'h000, 32'h0);
    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule